// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a load strobe is accepted, the whole incoming address is captured. The two lowest bits become the starting offset of the burst, and the remaining upper bits are held in a base register. After that, every clock edge with the advance input high moves the low bits to the next position in the burst. An edge with advance low keeps the address where it is.

Two orderings are available. Linear order adds the beat number to the start offset, modulo 4. Interleaved order XORs the start offset with the beat number. The ordering comes from a mode strap that stays fixed during operation. A build parameter can also fix the ordering at elaboration time, in which case the strap is unused.

The beat number is held in a counter of its own, separate from the captured start offset. Either ordering therefore wraps back to the start address after four steps. The storage array that consumes the address is not part of this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no load, `addr_o` is all zeros.
- R2: After a clock edge with `load_i` high, `addr_o` equals the `load_addr_i` sampled at that edge.
- R3: With `mode_i` = 0 (linear), each edge with `adv_i` high and `load_i` low sets the low two bits of `addr_o` to (start + beats advanced) modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R4: With `mode_i` = 1 (interleaved), each edge with `adv_i` high and `load_i` low sets the low two bits to start XOR beats advanced. Start 01 gives 01, 00, 11, 10. Start 10 gives 10, 11, 00, 01.
- R5: An edge with both `adv_i` and `load_i` low leaves `addr_o` unchanged.
- R6: After four advances from a load, the low two bits return to the loaded start offset. The four addresses seen within one burst are all different.
- R7: Bits above bit 1 of `addr_o` change only on a load edge. `load_addr_i` has no effect on edges without a load.
- R8: When `load_i` and `adv_i` are both high on the same edge, the load wins and the burst restarts at the loaded address with beat zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Accepted address strobe; captures `load_addr_i` |
| load_addr_i | input | ADDR_W | External address to capture |
| adv_i | input | 1 | Step to the next burst address (active high) |
| mode_i | input | 1 | Ordering strap: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
Some properties are checked on every cycle by assertions: a load presents the sampled address, an idle edge holds the address, the upper bits stay put unless a load occurs, the beat counter restarts on a load and steps by one modulo 4 on an advance, and a load takes priority over a coinciding advance. The actual ordering can only be shown by the bench's scenarios. These include the linear and interleaved sequences from different starting offsets, wrap-around after the fourth beat, holds placed in the middle of a burst, and a reset in mid-burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // How the beat number is combined with the start offset
   typedef enum logic [1:0] {
      ORD_LINEAR      = 2'd0,
      ORD_INTERLEAVED = 2'd1,
      ORD_STRAP       = 2'd2
   } order_sel_e;

   localparam int unsigned BURST_OFS_W = 2;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] beat_o
);

   localparam logic [BEAT_W-1:0] BEAT_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

   generate
      if (BEAT_W < 1) begin : g_bad_width
         $error("burst_beat_ctr: BEAT_W must be at least 1");
      end
   endgenerate

   logic [BEAT_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (restart_i) begin
         beat_q <= '0;
      end else if (step_i) begin
         beat_q <= beat_q + BEAT_ONE;
      end
   end

   assign beat_o = beat_q;

   // R8: a restart returns the beat to zero, whatever the step input does
   p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (beat_o == '0));

   // R6: a step moves the beat forward by exactly one, wrapping modulo 2^BEAT_W
   p_beat_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !restart_i) |=> (beat_o == $past(beat_o) + BEAT_ONE));

   // R5: no restart and no step keeps the beat
   p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !restart_i) |=> $stable(beat_o));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFS_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [OFS_W-1:0]  start_o,
   output logic [ADDR_W-1:0] base_o
);

   localparam int unsigned UP_W = ADDR_W - OFS_W;

   generate
      if (ADDR_W <= OFS_W) begin : g_bad_width
         $error("burst_base_reg: ADDR_W must exceed OFS_W");
      end
   endgenerate

   logic [OFS_W-1:0] start_q;
   logic [UP_W-1:0]  upper_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         upper_q <= '0;
      end else if (load_i) begin
         start_q <= addr_i[OFS_W-1:0];
         upper_q <= addr_i[ADDR_W-1:OFS_W];
      end
   end

   assign start_o = start_q;
   assign base_o  = {upper_q, {OFS_W{1'b0}}};

   // R7: without a load the captured address stays frozen
   p_base_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(base_o) && $stable(start_o)));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int unsigned BEAT_W = 2,
   parameter order_sel_e  ORDER  = ORD_STRAP
) (
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  logic              mode_i,
   output logic [BEAT_W-1:0] ofs_o
);

   logic [BEAT_W-1:0] lin_ofs;
   logic [BEAT_W-1:0] ilv_ofs;

   always_comb begin
      lin_ofs = start_i + beat_i;
      ilv_ofs = start_i ^ beat_i;
   end

   generate
      if (ORDER == ORD_LINEAR) begin : g_linear
         logic unused_mode;
         assign unused_mode = mode_i;
         assign ofs_o = lin_ofs;
      end else if (ORDER == ORD_INTERLEAVED) begin : g_interleaved
         logic unused_mode;
         assign unused_mode = mode_i;
         assign ofs_o = ilv_ofs;
      end else begin : g_strap
         assign ofs_o = mode_i ? ilv_ofs : lin_ofs;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter order_sel_e  ORDER  = ORD_STRAP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              adv_i,
   input  logic              mode_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned OFS_W = BURST_OFS_W;

   generate
      if (ADDR_W < OFS_W + 1) begin : g_bad_addr
         $error("burst_addr_seq: ADDR_W too small for a burst offset");
      end
   endgenerate

   logic [OFS_W-1:0]  start_ofs;
   logic [OFS_W-1:0]  beat;
   logic [OFS_W-1:0]  cur_ofs;
   logic [ADDR_W-1:0] base_addr;

   burst_base_reg #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .addr_i  (load_addr_i),
      .start_o (start_ofs),
      .base_o  (base_addr)
   );

   // a load on the same edge as an advance restarts the beat (priority in counter)
   burst_beat_ctr #(
      .BEAT_W (OFS_W)
   ) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (load_i),
      .step_i    (adv_i),
      .beat_o    (beat)
   );

   burst_order_map #(
      .BEAT_W (OFS_W),
      .ORDER  (ORDER)
   ) u_map (
      .start_i (start_ofs),
      .beat_i  (beat),
      .mode_i  (mode_i),
      .ofs_o   (cur_ofs)
   );

   assign addr_o = {base_addr[ADDR_W-1:OFS_W], cur_ofs};

   // R2: a load presents the sampled address on the next cycle
   p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == $past(load_addr_i)));

   // R8: load wins over a simultaneous advance
   p_load_over_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && adv_i) |=> (addr_o == $past(load_addr_i)));

   // R5: an idle edge holds the address (mode is a static strap)
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i && $stable(mode_i)) |=> $stable(addr_o));

   // R7: upper bits move only on a load
   p_upper_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o[ADDR_W-1:OFS_W]));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW = 16;
   localparam int unsigned NV = 22;

   // {load, adv, mode, load_addr[15:0], expected addr_o[15:0]}
   localparam logic [34:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b0, 16'h1235, 16'h1235},  // R2 load, linear start 01
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h1236},  // R3
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h1237},  // R3
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h1234},  // R3 wrap of offset
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h1235},  // R6 back to start
      {1'b0, 1'b0, 1'b0, 16'h0000, 16'h1235},  // R5 hold
      {1'b1, 1'b0, 1'b1, 16'hABC9, 16'hABC9},  // R2 load, interleaved start 01
      {1'b0, 1'b1, 1'b1, 16'h0000, 16'hABC8},  // R4
      {1'b0, 1'b1, 1'b1, 16'h5555, 16'hABCB},  // R4
      {1'b0, 1'b0, 1'b1, 16'h5555, 16'hABCB},  // R5 hold mid-burst
      {1'b0, 1'b1, 1'b1, 16'h5555, 16'hABCA},  // R4
      {1'b0, 1'b1, 1'b1, 16'h5555, 16'hABC9},  // R6
      {1'b1, 1'b0, 1'b1, 16'h0F02, 16'h0F02},  // R2 interleaved start 10
      {1'b0, 1'b1, 1'b1, 16'hAAAA, 16'h0F03},  // R4
      {1'b0, 1'b1, 1'b1, 16'hAAAA, 16'h0F00},  // R4
      {1'b0, 1'b1, 1'b1, 16'hAAAA, 16'h0F01},  // R4
      {1'b1, 1'b1, 1'b0, 16'h5553, 16'h5553},  // R8 load with advance
      {1'b0, 1'b1, 1'b0, 16'h0000, 16'h5550},  // R8 beat restarted, linear 11->00
      {1'b1, 1'b0, 1'b0, 16'h7FFE, 16'h7FFE},  // R2
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h7FFF},  // R7 upper kept
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h7FFC},  // R7 no carry into upper
      {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h7FFD}   // R3
   };

   logic          clk;
   logic          rst_n;
   logic          load_i;
   logic [AW-1:0] load_addr_i;
   logic          adv_i;
   logic          mode_i;
   logic [AW-1:0] addr_o;

   int checks;
   int errors;
   bit done;

   burst_addr_seq #(.ADDR_W(AW)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .load_addr_i (load_addr_i),
      .adv_i       (adv_i),
      .mode_i      (mode_i),
      .addr_o      (addr_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, sample a quarter period later
   task automatic cycle(input logic ld, input logic adv, input logic md, input logic [AW-1:0] a);
      @(negedge clk);
      load_i = ld; adv_i = adv; mode_i = md; load_addr_i = a;
      @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   initial begin
      #(CLK_PERIOD*5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] seen;
      checks = 0; errors = 0; done = 1'b0;
      rst_n = 1'b0; load_i = 1'b0; adv_i = 1'b0; mode_i = 1'b0; load_addr_i = '0;
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      check("R1 in reset", addr_o, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      cycle(1'b0, 1'b0, 1'b0, 16'hDEAD);
      check("R1 after release", addr_o, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         cycle(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16]);
         check($sformatf("vector %0d R2-R8 table", i), addr_o, VEC[i][15:0]);
      end

      // R6: four distinct interleaved addresses from start 11, then wrap
      cycle(1'b1, 1'b0, 1'b1, 16'h4443);
      seen = 4'b0;
      seen[addr_o[1:0]] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         cycle(1'b0, 1'b1, 1'b1, 16'h0000);
         seen[addr_o[1:0]] = 1'b1;
      end
      check("R6 all offsets visited", {12'h0, seen}, 16'h000F);
      cycle(1'b0, 1'b1, 1'b1, 16'h0000);
      check("R6 wrap to start", addr_o, 16'h4443);

      // R5: long hold with load address toggling
      for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 1'b1, 16'h1111 * k);
      check("R5 R7 hold ignores load address", addr_o, 16'h4443);

      // R1: reset mid-burst
      cycle(1'b1, 1'b0, 1'b0, 16'h2222);
      cycle(1'b0, 1'b1, 1'b0, 16'h0000);
      check("R3 before reset", addr_o, 16'h2223);
      @(negedge clk);
      rst_n = 1'b0; adv_i = 1'b0;
      #(CLK_PERIOD/4);
      check("R1 mid-burst reset", addr_o, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      cycle(1'b0, 1'b1, 1'b0, 16'h0000);
      check("R1 R3 step from cleared state", addr_o, 16'h0001);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule